// File: doc/BRIEF.md
# Nine-Level Phase-Shifted Carrier Modulator for Cascaded Clamped Bridges

This block drives the sixteen power switches of one inverter phase made from two series-connected cells. Each cell is a full bridge whose two legs are three-level neutral-clamped legs. The legs can put out +1, 0 or -1 units. One cell adds a difference of -2 to +2 units, and the phase adds -4 to +4 units, which is nine levels.

A phase accumulator addresses a 64-point sine. The sine is scaled by a programmable amplitude index and by the carrier half-period, and then it is compared against a pair of in-phase triangular carriers. One carrier covers the positive half of the range and the other covers the negative half. The first cell's second leg sees the inverted reference. The second cell uses the same carrier pair advanced by one eighth of a carrier period, and its reference pair is swapped. Each complementary switch pair passes through a programmable dead band before it reaches the gate pins.

The level code of each leg and the summed phase level are also brought out, so that a system model can track the commanded voltage.

Top module: `npcPscModulator`

## Requirements
- R1: While `rstN` is low, the phase accumulator, both carrier positions and all active settings are zero. Every leg code reads 0 and every leg holds the clamped state. With `enable` high, that state gives `gates` = 16'h6666.
- R2: Carrier A is a triangle with value `pos` for `pos <= H` and `2H - pos` otherwise, where `pos` counts 0 to 2H-1 and H is the active half-period. A leg's code becomes +1 when its reference exceeds the carrier value, -1 when the reference is below (carrier - H), and 0 otherwise. The code is registered one clock after the state it comes from and is read as a 2-bit two's complement field at `legLevels[2i+1:2i]`.
- R3: Gate bit `4i+0` is the outer upper switch, `4i+1` the inner upper, `4i+2` the inner lower and `4i+3` the outer lower of leg i. Code +1 asks for bits 0 and 1 on, code 0 for bits 1 and 2, and code -1 for bits 2 and 3. Bits 0 and 2 are never high together, and neither are bits 1 and 3.
- R4: The reference is r = floor(s * M * H / 2^15). Here s = round(128 * sin(2*pi*k/64)), k is the top six bits of the 16-bit phase accumulator, and M is the active 8-bit index. Legs 0 and 3 compare +r and legs 1 and 2 compare -r. An index of 0 holds every leg at code 0.
- R5: Legs 0 and 1 use carrier A. Legs 2 and 3 use carrier B, whose position starts at floor(H/4) whenever carrier A restarts and then steps and wraps in the same way.
- R6: `phaseLevel` is a 4-bit two's complement value equal to (leg0 - leg1) - (leg2 - leg3), registered in the same clock as the leg codes, and it lies in -4..+4.
- R7: A high `cfgWrite` captures the half-period, step and index into a shadow copy. The shadow copy becomes active only in the clock where carrier A's position wraps to 0. The phase accumulator adds the active step on every clock.
- R8: When a pair's requested state changes, both of its gates stay low for exactly `deadTime` clocks, and then the new gate rises. A new change restarts the count.
- R9: With `enable` low, all sixteen gates are low in the same cycle. Codes and counters keep running.
- R10: With H = 8, index 230 and step 102, one fundamental period shows all nine phase levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Gate enable, high to drive |
| cfgWrite | input | 1 | Capture strobe for the shadow settings |
| halfPeriod | input | CW (10) | Carrier half-period in clocks |
| fcw | input | PW (16) | Phase accumulator step |
| modIndex | input | MW (8) | Amplitude index, 256 = 1.0 |
| deadTime | input | DW (6) | Dead band in clocks |
| gates | output | 16 | Switch gate drives, four per leg |
| legLevels | output | 8 | Signed 2-bit level code per leg |
| phaseLevel | output | 4 | Signed summed phase level |

## Verification
The assertions check on every cycle the properties that hold regardless of the waveform. No complementary pair conducts at once, no leg code takes the unused value, the phase level matches the sum of the legs and stays within its range, disable clears every gate, and no gate rises straight after its partner while a dead band is set. Only the bench's scenarios can show the numbers themselves. These are the sine scaling, the carrier fold and the one-eighth shift of the second carrier, the exact dead-band length, the hold of new settings until the carrier wraps, and the appearance of all nine levels. The bench checks them against a cycle model built from the requirements, over a sweep of half-periods and indices.

// File: rtl/npcPscPkg.sv
`timescale 1ns/1ps
package npcPscPkg;
  localparam int SINE_IDX_W = 6;
  localparam int SINE_W     = 9;
  localparam int SINE_FRAC  = 7;
  localparam int LEGS       = 4;
  localparam int SW_PER_LEG = 4;

  typedef struct packed {
    logic cfgLoad;  // active settings take the shadow copy this clock
    logic gateEn;   // gates may be driven
  } strobeT;

  // first quadrant of a 64-point sine, amplitude 128
  function automatic logic signed [SINE_W-1:0] quarterWave(input logic [4:0] k);
    case (k)
      5'd0:  quarterWave = 9'sd0;
      5'd1:  quarterWave = 9'sd13;
      5'd2:  quarterWave = 9'sd25;
      5'd3:  quarterWave = 9'sd37;
      5'd4:  quarterWave = 9'sd49;
      5'd5:  quarterWave = 9'sd60;
      5'd6:  quarterWave = 9'sd71;
      5'd7:  quarterWave = 9'sd81;
      5'd8:  quarterWave = 9'sd91;
      5'd9:  quarterWave = 9'sd99;
      5'd10: quarterWave = 9'sd106;
      5'd11: quarterWave = 9'sd113;
      5'd12: quarterWave = 9'sd118;
      5'd13: quarterWave = 9'sd122;
      5'd14: quarterWave = 9'sd126;
      5'd15: quarterWave = 9'sd127;
      default: quarterWave = 9'sd128;
    endcase
  endfunction

  function automatic logic signed [SINE_W-1:0] sineLookup(input logic [SINE_IDX_W-1:0] idx);
    logic [4:0] k;
    logic signed [SINE_W-1:0] mag;
    k = idx[4] ? (5'd16 - {1'b0, idx[3:0]}) : {1'b0, idx[3:0]};
    mag = quarterWave(k);
    sineLookup = idx[5] ? -mag : mag;
  endfunction

  function automatic logic signed [3:0] widenLevel(input logic [1:0] code);
    widenLevel = {{2{code[1]}}, code};
  endfunction
endpackage

// File: rtl/npcPscCtrl.sv
`timescale 1ns/1ps
module npcPscCtrl
  import npcPscPkg::*;
#(
  parameter int CW = 10,
  parameter int PW = 16,
  parameter int MW = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  cfgWrite,
  input  logic [CW-1:0]         halfIn,
  input  logic [PW-1:0]         fcwIn,
  input  logic [MW-1:0]         miIn,
  output strobeT                strobe,
  output logic [CW-1:0]         triA,
  output logic [CW-1:0]         triB,
  output logic [CW-1:0]         actHalf,
  output logic [SINE_IDX_W-1:0] sineIdx,
  output logic [MW-1:0]         shMi
);
  localparam int PCW = CW + 1;

  logic [PCW-1:0] posA, posB, nextA, nextB, fullCount, halfExt, preloadB;
  logic [PW-1:0]  acc, actFcw, shFcw;
  logic [CW-1:0]  shHalf;
  logic           wrapNow;

  always_comb begin
    fullCount = {actHalf, 1'b0};
    halfExt   = {1'b0, actHalf};
    nextA     = posA + 1'b1;
    nextB     = posB + 1'b1;
    wrapNow   = (nextA >= fullCount);
    preloadB  = {2'b00, shHalf[CW-1:2]};   // one eighth of the new full period
    triA      = (posA <= halfExt) ? posA[CW-1:0] : CW'(fullCount - posA);
    triB      = (posB <= halfExt) ? posB[CW-1:0] : CW'(fullCount - posB);
    sineIdx   = acc[PW-1 -: SINE_IDX_W];
    strobe.cfgLoad = wrapNow;
    strobe.gateEn  = enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posA    <= '0;
      posB    <= '0;
      acc     <= '0;
      actHalf <= '0;
      actFcw  <= '0;
      shHalf  <= '0;
      shFcw   <= '0;
      shMi    <= '0;
    end else begin
      acc <= acc + actFcw;
      if (cfgWrite) begin
        shHalf <= halfIn;
        shFcw  <= fcwIn;
        shMi   <= miIn;
      end
      if (wrapNow) begin
        posA    <= '0;
        posB    <= preloadB;
        actHalf <= shHalf;
        actFcw  <= shFcw;
      end else begin
        posA <= nextA;
        posB <= (nextB >= fullCount) ? '0 : nextB;
      end
    end
  end
endmodule

// File: rtl/npcPscPath.sv
`timescale 1ns/1ps
module npcPscPath
  import npcPscPkg::*;
#(
  parameter int CW = 10,
  parameter int MW = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgLoad,
  input  logic [CW-1:0]         triA,
  input  logic [CW-1:0]         triB,
  input  logic [CW-1:0]         half,
  input  logic [SINE_IDX_W-1:0] sineIdx,
  input  logic [MW-1:0]         shMi,
  output logic [2*LEGS-1:0]     legLevels,
  output logic [3:0]            phaseLevel,
  output logic [LEGS-1:0]       swUpper,
  output logic [LEGS-1:0]       swInner
);
  localparam int SHIFT = SINE_FRAC + MW;
  localparam int PRODW = SINE_W + MW + CW + 2;
  localparam int REFW  = CW + 2;

  logic [MW-1:0]              actMi;
  logic signed [SINE_W-1:0]   sineVal;
  logic signed [PRODW-1:0]    sineExt, miExt, halfExt, prod;
  logic signed [REFW-1:0]     refPos, halfRef;
  logic [1:0]                 lvlNext [LEGS];
  logic signed [3:0]          phaseNext;

  always_comb begin
    sineVal = sineLookup(sineIdx);
    sineExt = {{(PRODW-SINE_W){sineVal[SINE_W-1]}}, sineVal};
    miExt   = {{(PRODW-MW){1'b0}}, actMi};
    halfExt = {{(PRODW-CW){1'b0}}, half};
    prod    = sineExt * miExt * halfExt;
    refPos  = REFW'(prod >>> SHIFT);
    halfRef = {2'b00, half};
  end

  for (genvar g = 0; g < LEGS; g++) begin : gLeg
    logic signed [REFW-1:0] legRef, upperCar, lowerCar;
    always_comb begin
      legRef   = (g == 1 || g == 2) ? -refPos : refPos;
      upperCar = (g < 2) ? {2'b00, triA} : {2'b00, triB};
      lowerCar = upperCar - halfRef;
      if (legRef > upperCar)      lvlNext[g] = 2'b01;
      else if (legRef < lowerCar) lvlNext[g] = 2'b11;
      else                        lvlNext[g] = 2'b00;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        legLevels[2*g +: 2] <= 2'b00;
        swUpper[g]          <= 1'b0;
        swInner[g]          <= 1'b1;
      end else begin
        legLevels[2*g +: 2] <= lvlNext[g];
        swUpper[g]          <= (lvlNext[g] == 2'b01);
        swInner[g]          <= (lvlNext[g] != 2'b11);
      end
    end
  end

  always_comb
    phaseNext = widenLevel(lvlNext[0]) - widenLevel(lvlNext[1])
              - widenLevel(lvlNext[2]) + widenLevel(lvlNext[3]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMi      <= '0;
      phaseLevel <= '0;
    end else begin
      if (cfgLoad) actMi <= shMi;
      phaseLevel <= phaseNext;
    end
  end
endmodule

// File: rtl/npcDeadBand.sv
`timescale 1ns/1ps
module npcDeadBand #(
  parameter int DW      = 6,
  parameter bit RST_VAL = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          want,
  input  logic [DW-1:0] dtCycles,
  input  logic          gateEn,
  output logic          hiGate,
  output logic          loGate
);
  logic          cur;
  logic [DW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur     <= RST_VAL;
      holdCnt <= '0;
    end else if (want != cur) begin
      cur     <= want;
      holdCnt <= dtCycles;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    hiGate = gateEn && (holdCnt == '0) && cur;
    loGate = gateEn && (holdCnt == '0) && !cur;
  end
endmodule

// File: rtl/npcPscGates.sv
`timescale 1ns/1ps
module npcPscGates
  import npcPscPkg::*;
#(
  parameter int DW = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [LEGS-1:0]            swUpper,
  input  logic [LEGS-1:0]            swInner,
  input  logic [DW-1:0]              dtCycles,
  input  logic                       gateEn,
  output logic [LEGS*SW_PER_LEG-1:0] gates
);
  for (genvar g = 0; g < LEGS; g++) begin : gPair
    npcDeadBand #(.DW(DW), .RST_VAL(1'b0)) uOuter (
      .clk(clk), .rstN(rstN), .want(swUpper[g]), .dtCycles(dtCycles), .gateEn(gateEn),
      .hiGate(gates[SW_PER_LEG*g + 0]), .loGate(gates[SW_PER_LEG*g + 2])
    );
    npcDeadBand #(.DW(DW), .RST_VAL(1'b1)) uInner (
      .clk(clk), .rstN(rstN), .want(swInner[g]), .dtCycles(dtCycles), .gateEn(gateEn),
      .hiGate(gates[SW_PER_LEG*g + 1]), .loGate(gates[SW_PER_LEG*g + 3])
    );
  end
endmodule

// File: rtl/npcPscModulator.sv
`timescale 1ns/1ps
module npcPscModulator
  import npcPscPkg::*;
#(
  parameter int CW = 10,
  parameter int PW = 16,
  parameter int MW = 8,
  parameter int DW = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic                       cfgWrite,
  input  logic [CW-1:0]              halfPeriod,
  input  logic [PW-1:0]              fcw,
  input  logic [MW-1:0]              modIndex,
  input  logic [DW-1:0]              deadTime,
  output logic [LEGS*SW_PER_LEG-1:0] gates,
  output logic [2*LEGS-1:0]          legLevels,
  output logic [3:0]                 phaseLevel
);
  strobeT                  strobe;
  logic [CW-1:0]           triA, triB, actHalf;
  logic [SINE_IDX_W-1:0]   sineIdx;
  logic [MW-1:0]           shMi;
  logic [LEGS-1:0]         swUpper, swInner;

  npcPscCtrl #(.CW(CW), .PW(PW), .MW(MW)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .halfIn(halfPeriod), .fcwIn(fcw), .miIn(modIndex),
    .strobe(strobe), .triA(triA), .triB(triB), .actHalf(actHalf),
    .sineIdx(sineIdx), .shMi(shMi)
  );

  npcPscPath #(.CW(CW), .MW(MW)) uPath (
    .clk(clk), .rstN(rstN), .cfgLoad(strobe.cfgLoad),
    .triA(triA), .triB(triB), .half(actHalf), .sineIdx(sineIdx), .shMi(shMi),
    .legLevels(legLevels), .phaseLevel(phaseLevel),
    .swUpper(swUpper), .swInner(swInner)
  );

  npcPscGates #(.DW(DW)) uGates (
    .clk(clk), .rstN(rstN), .swUpper(swUpper), .swInner(swInner),
    .dtCycles(deadTime), .gateEn(strobe.gateEn), .gates(gates)
  );
endmodule

// File: rtl/npcPscModulator_checker.sv
`timescale 1ns/1ps
module npcPscModulator_checker
  import npcPscPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        dtNonZero,
  input logic [15:0] gates,
  input logic [7:0]  legLevels,
  input logic [3:0]  phaseLevel
);
  logic [3:0]        outerClash, innerClash, badCode;
  logic signed [3:0] legSum;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      outerClash[i] = gates[4*i] & gates[4*i+2];
      innerClash[i] = gates[4*i+1] & gates[4*i+3];
      badCode[i]    = (legLevels[2*i +: 2] == 2'b10);
    end
    legSum = widenLevel(legLevels[1:0]) - widenLevel(legLevels[3:2])
           - widenLevel(legLevels[5:4]) + widenLevel(legLevels[7:6]);
  end

  a_r3_no_shoot_through: assert property (@(posedge clk) disable iff (!rstN)
    (outerClash == 4'b0) && (innerClash == 4'b0));

  a_r2_legal_leg_code: assert property (@(posedge clk) disable iff (!rstN)
    badCode == 4'b0);

  a_r6_phase_is_leg_sum: assert property (@(posedge clk) disable iff (!rstN)
    $signed(phaseLevel) == legSum);

  a_r6_phase_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(phaseLevel) >= -4) && ($signed(phaseLevel) <= 4));

  a_r9_disable_clears_gates: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (gates == 16'h0000));

  for (genvar p = 0; p < 8; p++) begin : gGap
    localparam int HI = 4*(p/2) + (p%2);
    localparam int LO = HI + 2;
    a_r8_gap_before_hi: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gates[HI]) && $past(dtNonZero)) |-> $past(!gates[LO]));
    a_r8_gap_before_lo: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gates[LO]) && $past(dtNonZero)) |-> $past(!gates[HI]));
  end
endmodule

bind npcPscModulator npcPscModulator_checker u_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .dtNonZero(deadTime != '0),
  .gates(gates), .legLevels(legLevels), .phaseLevel(phaseLevel)
);

// File: tb/npcPscModulator_bench.sv
`timescale 1ns/1ps
module npcPscModulator_bench;
  localparam int CW = 10, PW = 16, MW = 8, DW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0, enable = 1'b0, cfgWrite = 1'b0;
  logic [CW-1:0] halfPeriod = '0;
  logic [PW-1:0] fcw = '0;
  logic [MW-1:0] modIndex = '0;
  logic [DW-1:0] deadTime = '0;
  logic [15:0]   gates;
  logic [7:0]    legLevels;
  logic [3:0]    phaseLevel;

  npcPscModulator u_npcPscModulator (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .halfPeriod(halfPeriod), .fcw(fcw), .modIndex(modIndex), .deadTime(deadTime),
    .gates(gates), .legLevels(legLevels), .phaseLevel(phaseLevel)
  );

  int vectors = 0, miscompares = 0;
  string legTag = "R2";
  bit trackLevels = 1'b0;
  logic [8:0] seenMask = '0;

  // cycle model built from the requirements
  int mPosA, mPosB, mHalf, mFcw, mMi, sHalf, sFcw, sMi, mAcc;
  int expLeg [4];
  int expPhase;
  bit expS1 [4];
  bit expS2 [4];
  bit dbCur [8];
  int dbCnt [8];

  function automatic int refSine(int idx);
    real x;
    x = 128.0 * $sin(2.0 * 3.14159265358979 * idx / 64.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : $rtoi(x - 0.5);
  endfunction

  function automatic int fold(int pos, int half);
    return (pos <= half) ? pos : 2 * half - pos;
  endfunction

  always @(posedge clk or negedge rstN) begin : model
    longint prod;
    int r, idx, tA, tB, car, refv, lvl, nb;
    bit want, wrap;
    if (!rstN) begin
      mPosA = 0; mPosB = 0; mHalf = 0; mFcw = 0; mMi = 0;
      sHalf = 0; sFcw = 0; sMi = 0; mAcc = 0; expPhase = 0;
      for (int g = 0; g < 4; g++) begin expLeg[g] = 0; expS1[g] = 1'b0; expS2[g] = 1'b1; end
      for (int j = 0; j < 8; j++) begin dbCur[j] = (j % 2 == 1); dbCnt[j] = 0; end
    end else begin
      for (int j = 0; j < 8; j++) begin
        want = (j % 2 == 0) ? expS1[j/2] : expS2[j/2];
        if (want != dbCur[j]) begin dbCur[j] = want; dbCnt[j] = int'(deadTime); end
        else if (dbCnt[j] != 0) dbCnt[j] = dbCnt[j] - 1;
      end
      idx  = (mAcc >> 10) & 63;
      prod = longint'(refSine(idx)) * mMi * mHalf;
      r    = int'(prod >>> 15);
      tA   = fold(mPosA, mHalf);
      tB   = fold(mPosB, mHalf);
      for (int g = 0; g < 4; g++) begin
        refv = (g == 1 || g == 2) ? -r : r;
        car  = (g < 2) ? tA : tB;
        lvl  = (refv > car) ? 1 : ((refv < car - mHalf) ? -1 : 0);
        expLeg[g] = lvl;
        expS1[g]  = (lvl == 1);
        expS2[g]  = (lvl != -1);
      end
      expPhase = (expLeg[0] - expLeg[1]) - (expLeg[2] - expLeg[3]);
      wrap = (mPosA + 1 >= 2 * mHalf);
      mAcc = (mAcc + mFcw) & 32'h0000_FFFF;
      if (wrap) begin
        mPosA = 0; mPosB = sHalf / 4; mHalf = sHalf; mFcw = sFcw; mMi = sMi;
      end else begin
        mPosA = mPosA + 1;
        nb = mPosB + 1;
        mPosB = (nb >= 2 * mHalf) ? 0 : nb;
      end
      if (cfgWrite) begin sHalf = int'(halfPeriod); sFcw = int'(fcw); sMi = int'(modIndex); end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkNow();
    logic [15:0] eg;
    int act;
    string gTag;
    for (int g = 0; g < 4; g++) begin
      act = int'($signed(legLevels[2*g +: 2]));
      check(act == expLeg[g], (g < 2) ? legTag : "R5", act, expLeg[g]);
    end
    act = int'($signed(phaseLevel));
    check(act == expPhase, "R6", act, expPhase);
    if (trackLevels && act >= -4 && act <= 4) seenMask[act + 4] = 1'b1;
    for (int j = 0; j < 8; j++) begin
      eg[4*(j/2) + (j%2)]     = enable && (dbCnt[j] == 0) && dbCur[j];
      eg[4*(j/2) + (j%2) + 2] = enable && (dbCnt[j] == 0) && !dbCur[j];
    end
    gTag = !enable ? "R9" : ((deadTime != 0) ? "R8" : "R3");
    check(gates == eg, gTag, int'(gates), int'(eg));
  endtask

  task automatic run(int n);
    repeat (n) begin @(negedge clk); checkNow(); end
  endtask

  task automatic writeCfg(int h, int m, int f);
    halfPeriod = CW'(h); modIndex = MW'(m); fcw = PW'(f);
    cfgWrite = 1'b1;
    run(1);
    cfgWrite = 1'b0;
  endtask

  initial begin : watchdog
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stimulus
    // R1: reset state
    run(3);
    check(legLevels == 8'h00, "R1", int'(legLevels), 0);
    check(gates == 16'h0000, "R1", int'(gates), 0);
    rstN = 1'b1; enable = 1'b1;
    run(2);
    check(gates == 16'h6666, "R1", int'(gates), 16'h6666);
    check(phaseLevel == 4'h0, "R1", int'(phaseLevel), 0);

    // R9: disabled, gates off while the carriers run
    enable = 1'b0;
    writeCfg(8, 230, 102);
    run(60);

    // R10: one full fundamental shows nine levels
    enable = 1'b1;
    trackLevels = 1'b1;
    run(1400);
    trackLevels = 1'b0;
    check($countones(seenMask) == 9, "R10", $countones(seenMask), 9);

    // R8 with a dead band, R7 mid-period update held to the wrap
    deadTime = 6'd3;
    run(700);
    writeCfg(12, 128, 200);
    legTag = "R7";
    run(30);
    legTag = "R2";
    run(600);

    // R4: zero index silences every leg after the next wrap
    legTag = "R4";
    writeCfg(12, 0, 200);
    run(60);
    check(legLevels == 8'h00, "R4", int'(legLevels), 0);
    run(100);
    legTag = "R2";

    // sweep of half-periods and indices
    deadTime = 6'd1;
    for (int h = 4; h <= 9; h++) begin
      for (int k = 0; k < 3; k++) begin
        writeCfg(h, (k == 0) ? 64 : ((k == 1) ? 200 : 255), 300 + 50 * h);
        run(250);
      end
    end

    // R9: enable dropped mid-run
    enable = 1'b0;
    run(20);
    enable = 1'b1;
    deadTime = 6'd0;
    run(150);

    // R1: reset while running
    rstN = 1'b0;
    run(2);
    check(legLevels == 8'h00, "R1", int'(legLevels), 0);
    check(gates == 16'h6666, "R1", int'(gates), 16'h6666);
    rstN = 1'b1;
    run(20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule